// File: doc/BRIEF.md
# Interrupt Input Capture and Pending Logic

This block sits between a chip's interrupt sources and the per-core selection logic. It turns wire-level interrupt lines and a few software commands into one pending bit per interrupt ID per core. Two kinds of lines come in. Shared lines map to IDs 32 and up, and reach cores through a per-ID target mask. Private lines form one bank of 32 per core, map to IDs 0 to 31, and only ever affect their own core. Each ID is set to edge-triggered or level-sensitive and carries a handling-model bit. Private IDs keep one enable bit per core. Shared IDs have one enable bit common to all cores.

Software acts on the block through a single write strobe with an opcode, core, ID and data byte. A second strobe carries a software interrupt command word, and a third reports completion of an interrupt on a core. A level-sensitive line that is still raised gets pended again when it is enabled or completed. All strobes are plain single-cycle pulses with no back-pressure. Every pulse is accepted in the cycle it is high, and IDs at or beyond the configured count are ignored. The pending vector is a registered output, and a small combinational read port returns the enable, configuration, target and recorded level of one ID.

Top module: `irq_pend_top`

## Requirements
- R1: The block records the level of each line every cycle and acts only when a line differs from its recorded level. A line held high does not pend again after its pending bit is cleared.
- R2: When a line rises, the pending bits of the ID's targets are set, but only if the ID is edge-triggered or enabled. A level-sensitive, disabled ID does not pend.
- R3: When a line falls, only the recorded level changes. A pending bit that is already set stays set, and no pending bit drops unless a clear-pending write (opcode 2) occurs.
- R4: A set-enable write (opcode 0) enables the ID. If the ID is level-sensitive and its recorded level is high, the write also pends it for its targets.
- R5: A completion notice from core c for ID n pends n on c only if n is level-sensitive, enabled on c, recorded high and targets c. Private IDs target their own core.
- R6: A configuration write (opcode 3) stores data bit 0 as the handling model and data bit 1 as edge-triggered (1 = edge). For IDs below 32 the edge bit is stored as 1 on every write. The read port returns {edge, model}. After reset every bit is 0.
- R7: The software command word holds the ID in bits 9:0 and a filter in bits 25:24. Filter 0 pends the cores listed in bits 23:16. Filter 1 pends every core but the requester, filter 2 pends only the requester, and filter 3 pends all cores.
- R8: A clear-pending write (opcode 2) clears the ID's pending bit on every core, including for private IDs.
- R9: A target write (opcode 4) to a shared ID stores the low core-count bits of the data. Target writes to IDs below 32 have no effect. The target read returns 0 for IDs below 29 and only the reading core's bit for IDs 29 to 31.
- R10: A set-pending write (opcode 1) pends a private ID on the writing core only and a shared ID on its targets. Pending bit c*NID+n belongs to core c and ID n, where NID = 32 + shared line count.
- R11: After reset all pending bits, enables, targets and configuration bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shared_lines | input | NSH | Shared interrupt lines, bit j is ID 32+j |
| private_lines | input | NC*32 | Private lines, bit c*32+n is ID n of core c |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 3 | 0 set-enable, 1 set-pending, 2 clear-pending, 3 configure, 4 target |
| wr_core | input | CW | Core issuing the write |
| wr_id | input | 10 | Interrupt ID of the write |
| wr_data | input | 8 | Write data (configuration bits or target mask) |
| sgi_en | input | 1 | Software command strobe |
| sgi_core | input | CW | Requesting core of the command |
| sgi_word | input | 32 | Command word |
| done_en | input | 1 | Completion strobe |
| done_core | input | CW | Core reporting completion |
| done_id | input | 10 | Completed interrupt ID |
| rd_core | input | CW | Core viewpoint for the read port |
| rd_id | input | 10 | ID for the read port |
| rd_enable | output | 1 | Enable of rd_id as seen by rd_core |
| rd_cfg | output | 2 | {edge, model} of rd_id |
| rd_target | output | NC | Target mask of rd_id as seen by rd_core |
| rd_level | output | 1 | Recorded level of rd_id for rd_core |
| pending | output | NC*NID | Pending bits, bit c*NID+n |

## Verification
The bench holds a line high across a clear to expose a design that uses plain level sampling: such a design would pend the ID again at once. It drops a line that has already pended, where a design that clears pending on a fall would lose the interrupt. It clears a private ID from the other core, which a per-core clear would miss. It enables a raised level-sensitive line, then completes from the untargeted core and from the targeted core; a design without re-pend logic would stay silent, and one that ignores targets would pend the wrong core. It walks all four command filters, checks that private configuration writes force the edge bit, and checks the target reads for IDs 29 to 31, where a wrong design returns the stored mask.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned PRIV_IDS = 32;
  localparam int unsigned ID_W = 10;
  localparam int unsigned FIXED_TGT_LO = 29;

  typedef enum logic [2:0] {
    OP_SET_EN   = 3'd0,
    OP_SET_PEND = 3'd1,
    OP_CLR_PEND = 3'd2,
    OP_CONFIG   = 3'd3,
    OP_TARGET   = 3'd4
  } wr_op_e;
endpackage

// File: rtl/irq_level_track.sv
module irq_level_track #(
  parameter int NC  = 2,
  parameter int NSH = 32,
  localparam int NID = 32 + NSH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSH-1:0]           shared_lines,
  input  logic [NC*32-1:0]         private_lines,
  output logic [NC-1:0][NID-1:0]   level_v,
  output logic [NC-1:0][NID-1:0]   rise_v
);
  import irq_pend_pkg::*;

  logic [NC-1:0][PRIV_IDS-1:0] lvl_p;
  logic [NSH-1:0]              lvl_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_p <= '0;
      lvl_s <= '0;
    end else begin
      lvl_p <= private_lines;
      lvl_s <= shared_lines;
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_core
    assign level_v[c] = {lvl_s, lvl_p[c]};
    assign rise_v[c]  = {shared_lines & ~lvl_s,
                         private_lines[c*PRIV_IDS +: PRIV_IDS] & ~lvl_p[c]};
  end
endmodule

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank #(
  parameter int NC  = 2,
  parameter int NSH = 32,
  localparam int NID = 32 + NSH,
  localparam int CW  = (NC > 1) ? $clog2(NC) : 1,
  localparam int IXW = $clog2(NID),
  localparam int SXW = (NSH > 1) ? $clog2(NSH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              wr_op,
  input  logic [CW-1:0]           wr_core,
  input  logic [9:0]              wr_id,
  input  logic [7:0]              wr_data,
  input  logic [CW-1:0]           rd_core,
  input  logic [9:0]              rd_id,
  output logic [NID-1:0]          edge_v,
  output logic [NC-1:0][NID-1:0]  en_v,
  output logic [NC-1:0][NID-1:0]  tgt_v,
  output logic [NC-1:0][NID-1:0]  wr_reach,
  output logic                    rd_enable,
  output logic [1:0]              rd_cfg,
  output logic [NC-1:0]           rd_target
);
  import irq_pend_pkg::*;

  logic [NID-1:0]              edge_q, model_q;
  logic [NC-1:0][PRIV_IDS-1:0] en_p_q;
  logic [NSH-1:0]              en_s_q;
  logic [NSH-1:0][NC-1:0]      tgt_q;

  logic              wr_in_range, wr_private;
  logic [ID_W-1:0]   wr_off, rd_off;
  logic              unused_data;

  assign wr_in_range = wr_id < ID_W'(NID);
  assign wr_private  = wr_id < ID_W'(PRIV_IDS);
  assign wr_off      = wr_id - ID_W'(PRIV_IDS);
  assign rd_off      = rd_id - ID_W'(PRIV_IDS);
  assign unused_data = ^{wr_data, wr_off, rd_off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q  <= '0;
      model_q <= '0;
      en_p_q  <= '0;
      en_s_q  <= '0;
      tgt_q   <= '0;
    end else if (wr_en && wr_in_range) begin
      case (wr_op)
        OP_CONFIG: begin
          model_q[wr_id[IXW-1:0]] <= wr_data[0];
          edge_q[wr_id[IXW-1:0]]  <= wr_data[1] | wr_private;
        end
        OP_SET_EN: begin
          if (wr_private) en_p_q[wr_core][wr_id[4:0]] <= 1'b1;
          else            en_s_q[wr_off[SXW-1:0]]     <= 1'b1;
        end
        OP_TARGET: begin
          if (!wr_private) tgt_q[wr_off[SXW-1:0]] <= wr_data[NC-1:0];
        end
        default: ;
      endcase
    end
  end

  assign edge_v = edge_q;

  for (genvar c = 0; c < NC; c++) begin : g_core
    for (genvar i = 0; i < NID; i++) begin : g_id
      if (i < PRIV_IDS) begin : g_priv
        assign en_v[c][i]     = en_p_q[c][i];
        assign tgt_v[c][i]    = 1'b1;
        assign wr_reach[c][i] = (wr_id == ID_W'(i)) && (wr_core == CW'(c));
      end else begin : g_shared
        assign en_v[c][i]     = en_s_q[i-PRIV_IDS];
        assign tgt_v[c][i]    = tgt_q[i-PRIV_IDS][c];
        assign wr_reach[c][i] = (wr_id == ID_W'(i)) && tgt_q[i-PRIV_IDS][c];
      end
    end
  end

  always_comb begin
    rd_enable = 1'b0;
    rd_cfg    = 2'b00;
    rd_target = '0;
    if (rd_id < ID_W'(NID)) begin
      rd_enable = en_v[rd_core][rd_id[IXW-1:0]];
      rd_cfg    = {edge_q[rd_id[IXW-1:0]], model_q[rd_id[IXW-1:0]]};
      if (rd_id >= ID_W'(PRIV_IDS))
        rd_target = tgt_q[rd_off[SXW-1:0]];
      else if (rd_id >= ID_W'(FIXED_TGT_LO))
        rd_target = NC'(1) << rd_core;
    end
  end

  // R6
  cfg_edge_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == OP_CONFIG && wr_private) |=> edge_q[$past(wr_id[4:0])]);

  // R9
  tgt_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == OP_TARGET && wr_private) |=> $stable(tgt_q));
endmodule

// File: rtl/irq_sgi_decode.sv
module irq_sgi_decode #(
  parameter int NC = 2,
  localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] sgi_core,
  input  logic [31:0]   sgi_word,
  output logic [NC-1:0] core_mask,
  output logic [9:0]    sgi_id
);
  logic [NC-1:0] all_cores, self_core;
  logic          unused_word;

  assign all_cores   = '1;
  assign self_core   = NC'(1) << sgi_core;
  assign sgi_id      = sgi_word[9:0];
  assign unused_word = ^{sgi_word[31:26], sgi_word[23:16], sgi_word[15:10]};

  always_comb begin
    case (sgi_word[25:24])
      2'd0:    core_mask = sgi_word[16 +: NC];
      2'd1:    core_mask = all_cores & ~self_core;
      2'd2:    core_mask = self_core;
      default: core_mask = all_cores;
    endcase
  end

  // R7
  sgi_self_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_word[25:24] == 2'd1) |-> (!core_mask[sgi_core] && $countones(core_mask) == NC - 1));
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NC  = 2,
  parameter int NID = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NC-1:0][NID-1:0] set_v,
  input  logic [NID-1:0]         clr_v,
  output logic [NC-1:0][NID-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      for (int c = 0; c < NC; c++)
        pend_q[c] <= (pend_q[c] & ~clr_v) | set_v[c];
    end
  end
endmodule

// File: rtl/irq_pend_top.sv
module irq_pend_top #(
  parameter int NC  = 2,
  parameter int NSH = 32,
  localparam int NID = 32 + NSH,
  localparam int CW  = (NC > 1) ? $clog2(NC) : 1,
  localparam int IXW = $clog2(NID)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSH-1:0]      shared_lines,
  input  logic [NC*32-1:0]    private_lines,
  input  logic                wr_en,
  input  logic [2:0]          wr_op,
  input  logic [CW-1:0]       wr_core,
  input  logic [9:0]          wr_id,
  input  logic [7:0]          wr_data,
  input  logic                sgi_en,
  input  logic [CW-1:0]       sgi_core,
  input  logic [31:0]         sgi_word,
  input  logic                done_en,
  input  logic [CW-1:0]       done_core,
  input  logic [9:0]          done_id,
  input  logic [CW-1:0]       rd_core,
  input  logic [9:0]          rd_id,
  output logic                rd_enable,
  output logic [1:0]          rd_cfg,
  output logic [NC-1:0]       rd_target,
  output logic                rd_level,
  output logic [NC*NID-1:0]   pending
);
  import irq_pend_pkg::*;

  logic [NC-1:0][NID-1:0] level_v, rise_v, en_v, tgt_v, wr_reach, set_v, pend_q;
  logic [NID-1:0]         edge_v, wr_row, sgi_row, done_row, clr_v;
  logic [NC-1:0]          sgi_mask;
  logic [9:0]             sgi_id;

  irq_level_track #(.NC(NC), .NSH(NSH)) u_track (
    .clk, .rst_n, .shared_lines, .private_lines,
    .level_v, .rise_v
  );

  irq_cfg_bank #(.NC(NC), .NSH(NSH)) u_cfg (
    .clk, .rst_n, .wr_en, .wr_op, .wr_core, .wr_id, .wr_data,
    .rd_core, .rd_id, .edge_v, .en_v, .tgt_v, .wr_reach,
    .rd_enable, .rd_cfg, .rd_target
  );

  irq_sgi_decode #(.NC(NC)) u_sgi (
    .clk, .rst_n, .sgi_core, .sgi_word,
    .core_mask(sgi_mask), .sgi_id
  );

  for (genvar i = 0; i < NID; i++) begin : g_row
    assign wr_row[i]   = (wr_id   == ID_W'(i));
    assign sgi_row[i]  = (sgi_id  == ID_W'(i));
    assign done_row[i] = (done_id == ID_W'(i));
  end

  assign clr_v = (wr_en && wr_op == OP_CLR_PEND) ? wr_row : '0;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      set_v[c] = rise_v[c] & (edge_v | en_v[c]) & tgt_v[c];
      if (wr_en && wr_op == OP_SET_EN)
        set_v[c] |= wr_reach[c] & level_v[c] & ~edge_v;
      if (wr_en && wr_op == OP_SET_PEND)
        set_v[c] |= wr_reach[c];
      if (sgi_en && sgi_mask[c])
        set_v[c] |= sgi_row;
      if (done_en && done_core == CW'(c))
        set_v[c] |= done_row & ~edge_v & en_v[c] & level_v[c] & tgt_v[c];
    end
  end

  irq_pend_bank #(.NC(NC), .NID(NID)) u_pend (
    .clk, .rst_n, .set_v, .clr_v, .pend_q
  );

  assign pending  = pend_q;
  assign rd_level = (rd_id < ID_W'(NID)) ? level_v[rd_core][rd_id[IXW-1:0]] : 1'b0;

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_op == OP_CLR_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: tb/irq_pend_top_test.sv
module irq_pend_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC  = 2;
  localparam int NSH = 32;
  localparam int NID = 32 + NSH;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSH-1:0]  shared_lines;
  logic [NC*32-1:0] private_lines;
  logic            wr_en;
  logic [2:0]      wr_op;
  logic [0:0]      wr_core;
  logic [9:0]      wr_id;
  logic [7:0]      wr_data;
  logic            sgi_en;
  logic [0:0]      sgi_core;
  logic [31:0]     sgi_word;
  logic            done_en;
  logic [0:0]      done_core;
  logic [9:0]      done_id;
  logic [0:0]      rd_core;
  logic [9:0]      rd_id;
  logic            rd_enable;
  logic [1:0]      rd_cfg;
  logic [NC-1:0]   rd_target;
  logic            rd_level;
  logic [NC*NID-1:0] pending;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pend_top #(.NC(NC), .NSH(NSH)) uut (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pb(int c, int id);
    return pending[c*NID + id];
  endfunction

  task automatic wr(logic [2:0] op, int core, int id, logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_core = core[0:0]; wr_id = id[9:0]; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_shared(int j, logic v);
    @(negedge clk); shared_lines[j] = v; @(negedge clk);
  endtask

  task automatic set_private(int c, int id, logic v);
    @(negedge clk); private_lines[c*32 + id] = v; @(negedge clk);
  endtask

  task automatic sgi(int core, logic [1:0] filt, logic [7:0] list, int id);
    @(negedge clk);
    sgi_en = 1'b1; sgi_core = core[0:0];
    sgi_word = {6'b0, filt, list, 6'b0, id[9:0]};
    @(negedge clk);
    sgi_en = 1'b0;
  endtask

  task automatic done(int core, int id);
    @(negedge clk);
    done_en = 1'b1; done_core = core[0:0]; done_id = id[9:0];
    @(negedge clk);
    done_en = 1'b0;
  endtask

  task automatic test_reset();
    chk("R11", "pending after reset", longint'(pending == '0), 1);
    rd_core = 0; rd_id = 40; #1;
    chk("R11", "cfg after reset", rd_cfg, 0);
    chk("R11", "target after reset", rd_target, 0);
    chk("R11", "enable after reset", rd_enable, 0);
  endtask

  task automatic test_level_enable();
    wr(3'd4, 0, 32, 8'h02);
    set_shared(0, 1'b1);
    chk("R2", "level disabled rise core1", pb(1, 32), 0);
    rd_core = 1; rd_id = 32; #1;
    chk("R1", "recorded level high", rd_level, 1);
    wr(3'd0, 0, 32, 8'h00);
    chk("R4", "enable re-pend core1", pb(1, 32), 1);
    chk("R4", "enable untargeted core0", pb(0, 32), 0);
    wr(3'd2, 0, 32, 8'h00);
    set_shared(0, 1'b0);
  endtask

  task automatic test_edge_hold_fall();
    wr(3'd3, 0, 33, 8'h02);
    wr(3'd4, 0, 33, 8'h03);
    set_shared(1, 1'b1);
    chk("R2", "edge rise core0", pb(0, 33), 1);
    chk("R10", "edge rise core1 by target", pb(1, 33), 1);
    wr(3'd2, 1, 33, 8'h00);
    repeat (3) @(negedge clk);
    chk("R1", "held line no re-pend c0", pb(0, 33), 0);
    chk("R1", "held line no re-pend c1", pb(1, 33), 0);
    set_shared(1, 1'b0);
    set_shared(1, 1'b1);
    set_shared(1, 1'b0);
    chk("R3", "fall keeps pending c0", pb(0, 33), 1);
    chk("R3", "fall keeps pending c1", pb(1, 33), 1);
    wr(3'd2, 0, 33, 8'h00);
    chk("R8", "clear shared both", longint'(pb(0, 33) | pb(1, 33)), 0);
  endtask

  task automatic test_private();
    wr(3'd3, 0, 20, 8'h01);
    rd_core = 0; rd_id = 20; #1;
    chk("R6", "private cfg edge forced", rd_cfg, 3);
    wr(3'd3, 0, 40, 8'h01);
    rd_id = 40; #1;
    chk("R6", "shared cfg model only", rd_cfg, 1);
    set_private(0, 20, 1'b1);
    chk("R10", "private rise own core", pb(0, 20), 1);
    chk("R10", "private rise other core", pb(1, 20), 0);
    wr(3'd2, 1, 20, 8'h00);
    chk("R8", "clear from other core", pb(0, 20), 0);
    set_private(0, 20, 1'b0);
    wr(3'd1, 1, 5, 8'h00);
    chk("R10", "set-pend private writer", pb(1, 5), 1);
    chk("R10", "set-pend private other", pb(0, 5), 0);
    wr(3'd2, 0, 5, 8'h00);
    wr(3'd4, 0, 41, 8'h03);
    wr(3'd1, 0, 41, 8'h00);
    chk("R10", "set-pend shared both", longint'(pb(0, 41) & pb(1, 41)), 1);
    wr(3'd2, 0, 41, 8'h00);
  endtask

  task automatic test_sgi();
    sgi(0, 2'd0, 8'h02, 3);
    chk("R7", "filter0 list core1", {pb(1, 3), pb(0, 3)}, 2);
    wr(3'd2, 0, 3, 8'h00);
    sgi(0, 2'd1, 8'h00, 3);
    chk("R7", "filter1 others", {pb(1, 3), pb(0, 3)}, 2);
    wr(3'd2, 0, 3, 8'h00);
    sgi(0, 2'd2, 8'h02, 3);
    chk("R7", "filter2 self", {pb(1, 3), pb(0, 3)}, 1);
    wr(3'd2, 0, 3, 8'h00);
    sgi(1, 2'd3, 8'h00, 3);
    chk("R7", "filter3 all", {pb(1, 3), pb(0, 3)}, 3);
    wr(3'd2, 0, 3, 8'h00);
  endtask

  task automatic test_done();
    wr(3'd4, 0, 34, 8'h01);
    wr(3'd0, 0, 34, 8'h00);
    set_shared(2, 1'b1);
    chk("R2", "enabled level rise", pb(0, 34), 1);
    wr(3'd2, 0, 34, 8'h00);
    done(1, 34);
    chk("R5", "done untargeted core", longint'(pb(0, 34) | pb(1, 34)), 0);
    done(0, 34);
    chk("R5", "done targeted core", pb(0, 34), 1);
    chk("R5", "done other core stays", pb(1, 34), 0);
    wr(3'd3, 0, 34, 8'h02);
    wr(3'd2, 0, 34, 8'h00);
    done(0, 34);
    chk("R5", "done edge-triggered", pb(0, 34), 0);
    set_shared(2, 1'b0);
  endtask

  task automatic test_targets();
    rd_core = 1; rd_id = 30; #1;
    chk("R9", "id30 read core1", rd_target, 2);
    rd_core = 0; #1;
    chk("R9", "id30 read core0", rd_target, 1);
    rd_id = 10; #1;
    chk("R9", "id10 read zero", rd_target, 0);
    wr(3'd4, 0, 10, 8'h03);
    rd_core = 0; rd_id = 10; #1;
    chk("R9", "id10 write ignored", rd_target, 0);
    wr(3'd4, 0, 45, 8'hFD);
    rd_id = 45; #1;
    chk("R9", "shared target stored", rd_target, 1);
  endtask

  initial begin
    rst_n = 1'b0; shared_lines = '0; private_lines = '0;
    wr_en = 0; wr_op = 0; wr_core = 0; wr_id = 0; wr_data = 0;
    sgi_en = 0; sgi_core = 0; sgi_word = 0;
    done_en = 0; done_core = 0; done_id = 0; rd_core = 0; rd_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_level_enable();
    test_edge_hold_fall();
    test_private();
    test_sgi();
    test_done();
    test_targets();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule